// File: doc/BRIEF.md
# Comma-Framed 8B/10B Transmit Framer

This block turns one user payload into one fixed-length transmit frame of twelve 8B/10B symbols. Every frame opens with a K28.5 comma, which a receiver uses to find frame boundaries. Eleven data symbols follow it, and each one carries one byte of an 88-bit payload. The 120-bit result goes out as one parallel word to an external serializer. At the 40 MHz frame rate this fills a 4.8 Gb/s line and gives 3.52 Gb/s of user data.

A frame is built on each clock edge where the frame-go enable is high. When the data-valid flag is high, the payload bytes fill the eleven data slots. When it is low, every data slot carries a programmable idle byte, encoded as a data code. Running disparity is tracked one symbol at a time: through the comma, through every data symbol, and from one frame to the next. It restarts at negative after reset. This mode is transmit only and adds no error correction.

Top module: `cf_tx_framer`

## Requirements
- R1: While reset is asserted, and until the first frame, `frame_vld` is 0 and `frame_out` is all zeros. Running disparity starts negative, so the first frame after reset opens with the negative-disparity comma.
- R2: A high `frame_go` at a clock edge makes `frame_vld` high for exactly the following cycle, with the new frame on `frame_out`. With `frame_go` low, `frame_vld` is 0 and `frame_out` keeps its previous value.
- R3: Slot 0, `frame_out[119:110]`, is always K28.5. It is 0011111010 when the running disparity is negative and 1100000101 when it is positive.
- R4: With `data_valid` high, slot k (k = 1..11, `frame_out[119-10k -: 10]`) carries the D code of payload byte k-1, which is `payload[8(k-1) +: 8]`. The idle byte has no effect.
- R5: With `data_valid` low, all eleven data slots carry the D code of `idle_byte`. The payload has no effect.
- R6: Each symbol is laid out as the 6-bit sub-block abcdei followed by the 4-bit sub-block fghj, with bit a as the symbol's MSB. The bits follow the standard 8B/10B D-code tables for byte HGF EDCBA.
- R7: Running disparity is legal at every sub-block boundary. A sub-block with more ones than zeros appears only at negative disparity, and one with more zeros than ones appears only at positive disparity. Balanced 000111 and 0011 appear only at positive disparity, and balanced 111000 and 1100 only at negative. Disparity carries across frame boundaries and changes only when a frame is sent.
- R8: No data slot contains the 7-bit comma pattern 0011111 or 1100000 in its leading bits.
- R9: For D.x.7, the alternate 4-bit form (0111/1000) is used only in two cases: at negative disparity when x is 17, 18 or 20, and at positive disparity when x is 11, 13 or 14. Otherwise the primary form is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_go | input | 1 | Build and emit one frame at this edge |
| data_valid | input | 1 | 1: payload frame, 0: idle frame |
| payload | input | 88 | Eleven user bytes, byte 0 in bits 7:0 |
| idle_byte | input | 8 | Byte placed in all data slots of an idle frame |
| frame_out | output | 120 | Encoded frame, slot 0 in the top 10 bits |
| frame_vld | output | 1 | High for one cycle when a new frame is presented |

## Verification
The assertions check four things on every cycle: the one-cycle relation between `frame_go` and `frame_vld`, that the output holds between frames, that slot 0 is the comma with the polarity implied by the disparity history, and that the ones-count walk across each frame is legal. They also check that no data slot begins with a comma pattern. Only the bench scenarios can show the rest. Each data slot must decode back to the right payload or idle byte. Sub-block disparity rules and the alternate D.x.7 choice are checked across a sweep of all 256 byte values at both disparities. After a mid-stream reset, disparity must restart at negative.

// File: rtl/cf_tx_pkg.sv
package cf_tx_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // K28.5 in both polarities, abcdei fghj with a at bit 9
  localparam sym_t COMMA_NEG = 10'b0011111010;
  localparam sym_t COMMA_POS = 10'b1100000101;
endpackage

// File: rtl/cf_tx_dsym.sv
module cf_tx_dsym
  import cf_tx_pkg::*;
(
  input  byte_t din,
  input  logic  rd_in,   // 1 = positive running disparity
  output sym_t  sym,
  output logic  rd_out
);
  logic [4:0]        x5;
  logic [2:0]        y3;
  logic [SIX_W-1:0]  six_base;
  logic [SIX_W-1:0]  six;
  logic [FOUR_W-1:0] four_base;
  logic [FOUR_W-1:0] four;
  logic six_unbal, six_inv, rd_mid, use_alt, four_unbal, four_inv;

  assign x5 = din[4:0];
  assign y3 = din[7:5];

  // 5B/6B codes for negative disparity
  always_comb begin
    case (x5)
      5'd0:  six_base = 6'b100111;
      5'd1:  six_base = 6'b011101;
      5'd2:  six_base = 6'b101101;
      5'd3:  six_base = 6'b110001;
      5'd4:  six_base = 6'b110101;
      5'd5:  six_base = 6'b101001;
      5'd6:  six_base = 6'b011001;
      5'd7:  six_base = 6'b111000;
      5'd8:  six_base = 6'b111001;
      5'd9:  six_base = 6'b100101;
      5'd10: six_base = 6'b010101;
      5'd11: six_base = 6'b110100;
      5'd12: six_base = 6'b001101;
      5'd13: six_base = 6'b101100;
      5'd14: six_base = 6'b011100;
      5'd15: six_base = 6'b010111;
      5'd16: six_base = 6'b011011;
      5'd17: six_base = 6'b100011;
      5'd18: six_base = 6'b010011;
      5'd19: six_base = 6'b110010;
      5'd20: six_base = 6'b001011;
      5'd21: six_base = 6'b101010;
      5'd22: six_base = 6'b011010;
      5'd23: six_base = 6'b111010;
      5'd24: six_base = 6'b110011;
      5'd25: six_base = 6'b100110;
      5'd26: six_base = 6'b010110;
      5'd27: six_base = 6'b110110;
      5'd28: six_base = 6'b001110;
      5'd29: six_base = 6'b101110;
      5'd30: six_base = 6'b011110;
      default: six_base = 6'b101011;
    endcase
  end

  always_comb begin
    six_unbal = ($countones(six_base) != 3);
    six_inv   = rd_in && (six_unbal || (x5 == 5'd7));
    six       = six_inv ? ~six_base : six_base;
    rd_mid    = six_unbal ? ~rd_in : rd_in;
    use_alt   = (y3 == 3'd7) &&
                ((!rd_mid && ((x5 == 5'd17) || (x5 == 5'd18) || (x5 == 5'd20))) ||
                 ( rd_mid && ((x5 == 5'd11) || (x5 == 5'd13) || (x5 == 5'd14))));
    case (y3)
      3'd0: four_base = 4'b1011;
      3'd1: four_base = 4'b1001;
      3'd2: four_base = 4'b0101;
      3'd3: four_base = 4'b1100;
      3'd4: four_base = 4'b1101;
      3'd5: four_base = 4'b1010;
      3'd6: four_base = 4'b0110;
      default: four_base = use_alt ? 4'b0111 : 4'b1110;
    endcase
    four_unbal = ($countones(four_base) != 2);
    four_inv   = rd_mid && (four_unbal || (y3 == 3'd3));
    four       = four_inv ? ~four_base : four_base;
    rd_out     = four_unbal ? ~rd_mid : rd_mid;
    sym        = {six, four};
  end
endmodule

// File: rtl/cf_tx_comma.sv
module cf_tx_comma
  import cf_tx_pkg::*;
(
  input  logic rd_in,
  output sym_t sym,
  output logic rd_out
);
  // K28.5 is unbalanced in both forms, so disparity always flips
  assign sym    = rd_in ? COMMA_POS : COMMA_NEG;
  assign rd_out = ~rd_in;
endmodule

// File: rtl/cf_tx_chain.sv
module cf_tx_chain
  import cf_tx_pkg::*;
#(
  parameter int N_DATA = 11,
  localparam int PAY_W   = N_DATA * BYTE_W,
  localparam int FRAME_W = (N_DATA + 1) * SYM_W
) (
  input  logic [PAY_W-1:0]   bytes_in,
  input  logic               rd_in,
  output logic [FRAME_W-1:0] frame,
  output logic               rd_out
);
  logic [N_DATA:0] rd_c;
  sym_t            comma_sym;

  cf_tx_comma u_comma (
    .rd_in (rd_in),
    .sym   (comma_sym),
    .rd_out(rd_c[0])
  );
  assign frame[N_DATA*SYM_W +: SYM_W] = comma_sym;

  for (genvar i = 0; i < N_DATA; i++) begin : g_slot
    sym_t s;
    cf_tx_dsym u_dsym (
      .din   (bytes_in[i*BYTE_W +: BYTE_W]),
      .rd_in (rd_c[i]),
      .sym   (s),
      .rd_out(rd_c[i+1])
    );
    assign frame[(N_DATA-1-i)*SYM_W +: SYM_W] = s;
  end

  assign rd_out = rd_c[N_DATA];
endmodule

// File: rtl/cf_tx_framer.sv
module cf_tx_framer
  import cf_tx_pkg::*;
#(
  parameter int N_DATA = 11,
  localparam int PAY_W   = N_DATA * BYTE_W,
  localparam int FRAME_W = (N_DATA + 1) * SYM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_go,
  input  logic               data_valid,
  input  logic [PAY_W-1:0]   payload,
  input  logic [BYTE_W-1:0]  idle_byte,
  output logic [FRAME_W-1:0] frame_out,
  output logic               frame_vld
);
  logic [PAY_W-1:0]   sel_bytes;
  logic [FRAME_W-1:0] enc_frame;
  logic               enc_rd;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               vld_q, vld_d;
  logic               rd_q, rd_d;

  always_comb begin
    sel_bytes = data_valid ? payload : {N_DATA{idle_byte}};
  end

  cf_tx_chain #(.N_DATA(N_DATA)) u_chain (
    .bytes_in(sel_bytes),
    .rd_in   (rd_q),
    .frame   (enc_frame),
    .rd_out  (enc_rd)
  );

  // next state
  always_comb begin
    frame_d = frame_q;
    rd_d    = rd_q;
    vld_d   = 1'b0;
    if (frame_go) begin
      frame_d = enc_frame;
      rd_d    = enc_rd;
      vld_d   = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      rd_q    <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      rd_q    <= rd_d;
      vld_q   <= vld_d;
    end
  end

  assign frame_out = frame_q;
  assign frame_vld = vld_q;
endmodule

// File: rtl/cf_tx_framer_chk.sv
module cf_tx_framer_chk
  import cf_tx_pkg::*;
#(
  parameter int N_DATA = 11,
  localparam int FRAME_W = (N_DATA + 1) * SYM_W,
  localparam int NSYM    = N_DATA + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_go,
  input logic [FRAME_W-1:0] frame_out,
  input logic               frame_vld
);
  logic chk_rd;

  function automatic logic [1:0] walk(input logic [FRAME_W-1:0] f, input logic rd_i);
    logic rd, ok;
    int   n;
    rd = rd_i;
    ok = 1'b1;
    for (int s = 0; s < NSYM; s++) begin
      n = $countones(f[FRAME_W-1-s*SYM_W -: SYM_W]);
      if (n == 6) begin
        if (rd) ok = 1'b0;
        rd = 1'b1;
      end else if (n == 4) begin
        if (!rd) ok = 1'b0;
        rd = 1'b0;
      end else if (n != 5) begin
        ok = 1'b0;
      end
    end
    return {ok, rd};
  endfunction

  function automatic logic comma_free(input logic [FRAME_W-1:0] f);
    logic ok;
    logic [6:0] lead;
    ok = 1'b1;
    for (int s = 1; s < NSYM; s++) begin
      lead = f[FRAME_W-1-s*SYM_W -: 7];
      if ((lead == 7'b0011111) || (lead == 7'b1100000)) ok = 1'b0;
    end
    return ok;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_rd <= 1'b0;
    else if (frame_vld) chk_rd <= walk(frame_out, chk_rd)[0];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !frame_vld);
  assert_go_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> frame_vld);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_go |=> (!frame_vld && $stable(frame_out)));
  assert_comma_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> (frame_out[FRAME_W-1 -: SYM_W] == (chk_rd ? COMMA_POS : COMMA_NEG)));
  assert_disparity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> walk(frame_out, chk_rd)[1]);
  assert_no_comma_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> comma_free(frame_out));
endmodule

bind cf_tx_framer cf_tx_framer_chk #(.N_DATA(N_DATA)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_go (frame_go),
  .frame_out(frame_out),
  .frame_vld(frame_vld)
);

// File: tb/cf_tx_framer_bench.sv
module cf_tx_framer_bench;
  localparam int ND = 11;
  localparam int PW = ND * 8;
  localparam int FW = (ND + 1) * 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_go;
  logic          data_valid;
  logic [PW-1:0] payload;
  logic [7:0]    idle_byte;
  logic [FW-1:0] frame_out;
  logic          frame_vld;

  int checks = 0;
  int fails  = 0;
  logic [PW:0]   exp_q[$];   // {data_valid, expected bytes}
  logic          bench_rd;
  logic [FW-1:0] last_out;

  always #2 clk = ~clk;

  cf_tx_framer u_cf_tx_framer (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .data_valid(data_valid),
    .payload(payload), .idle_byte(idle_byte), .frame_out(frame_out), .frame_vld(frame_vld)
  );

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] tbl6(input int v);
    case (v)
      0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;  3: return 6'b110001;
      4: return 6'b110101;  5: return 6'b101001;  6: return 6'b011001;  7: return 6'b111000;
      8: return 6'b111001;  9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
      12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100; 15: return 6'b010111;
      16: return 6'b011011; 17: return 6'b100011; 18: return 6'b010011; 19: return 6'b110010;
      20: return 6'b001011; 21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
      24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110; 27: return 6'b110110;
      28: return 6'b001110; 29: return 6'b101110; 30: return 6'b011110; default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] tbl4(input int v);
    case (v)
      0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
      4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
    endcase
  endfunction

  // decode: returns {hit, value}; the complement is accepted only for unbalanced codes and D.7 / D.x.3
  function automatic logic [5:0] dec6(input logic [5:0] c);
    for (int v = 0; v < 32; v++) begin
      if (c == tbl6(v)) return {1'b1, 5'(v)};
      if ((c == ~tbl6(v)) && (($countones(tbl6(v)) != 3) || (v == 7))) return {1'b1, 5'(v)};
    end
    return 6'b0;
  endfunction

  function automatic logic [3:0] dec4(input logic [3:0] c);
    if ((c == 4'b0111) || (c == 4'b1000)) return 4'b1111;
    for (int v = 0; v < 8; v++) begin
      if (c == tbl4(v)) return {1'b1, 3'(v)};
      if ((c == ~tbl4(v)) && (($countones(tbl4(v)) != 2) || (v == 3))) return {1'b1, 3'(v)};
    end
    return 4'b0;
  endfunction

  // sub-block disparity walk (R7)
  task automatic walk6(input logic [5:0] c, inout logic rd, output bit ok);
    int n = $countones(c);
    if (n == 3)      ok = !((!rd && c == 6'b000111) || (rd && c == 6'b111000));
    else if (n == 4) begin ok = !rd; rd = 1'b1; end
    else if (n == 2) begin ok = rd;  rd = 1'b0; end
    else             ok = 1'b0;
  endtask

  task automatic walk4(input logic [3:0] c, inout logic rd, output bit ok);
    int n = $countones(c);
    if (n == 2)      ok = !((!rd && c == 4'b0011) || (rd && c == 4'b1100));
    else if (n == 3) begin ok = !rd; rd = 1'b1; end
    else if (n == 1) begin ok = rd;  rd = 1'b0; end
    else             ok = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      bench_rd = 1'b0;
      last_out = '0;
    end else if (frame_vld) begin
      logic [PW:0] item;
      logic [9:0]  sym, exp_comma;
      logic [5:0]  d6;
      logic [3:0]  d4;
      logic [7:0]  eb;
      logic        rdm;
      bit          ok6, ok4;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected frame", frame_out, '0);
      end else begin
        item = exp_q.pop_front();
        exp_comma = bench_rd ? 10'b1100000101 : 10'b0011111010;
        sym = frame_out[FW-1 -: 10];
        check(sym == exp_comma, "R3 comma slot", FW'(sym), FW'(exp_comma));
        walk6(sym[9:4], bench_rd, ok6);
        walk4(sym[3:0], bench_rd, ok4);
        check(ok6 && ok4, "R7 comma disparity", FW'(sym), '0);
        for (int s = 1; s <= ND; s++) begin
          sym = frame_out[FW-1-10*s -: 10];
          eb  = item[8*(s-1) +: 8];
          d6  = dec6(sym[9:4]);
          d4  = dec4(sym[3:0]);
          check(d6[5] && d4[3] && ({d4[2:0], d6[4:0]} == eb),
                item[PW] ? "R4/R6 payload byte" : "R5/R6 idle byte",
                FW'({d4, d6, sym}), FW'(eb));
          check((sym[9:3] != 7'b0011111) && (sym[9:3] != 7'b1100000), "R8 comma in data slot",
                FW'(sym), '0);
          walk6(sym[9:4], bench_rd, ok6);
          rdm = bench_rd;
          walk4(sym[3:0], bench_rd, ok4);
          check(ok6 && ok4, "R7 disparity", FW'(sym), FW'(s));
          if (eb[7:5] == 3'd7) begin
            bit alt_exp, alt_act;
            alt_exp = (!rdm && (eb[4:0] == 5'd17 || eb[4:0] == 5'd18 || eb[4:0] == 5'd20)) ||
                      ( rdm && (eb[4:0] == 5'd11 || eb[4:0] == 5'd13 || eb[4:0] == 5'd14));
            alt_act = (sym[3:0] == 4'b0111) || (sym[3:0] == 4'b1000);
            check(alt_exp == alt_act, "R9 alternate D.x.7", FW'(sym), FW'(alt_exp));
          end
        end
      end
      last_out = frame_out;
    end else begin
      check(frame_out == last_out, "R2 hold between frames", frame_out, last_out);
    end
  end

  // driver
  task automatic send(input logic dv, input logic [PW-1:0] pl, input logic [7:0] ib);
    @(negedge clk);
    frame_go   = 1'b1;
    data_valid = dv;
    payload    = pl;
    idle_byte  = ib;
    exp_q.push_back({dv, dv ? pl : {ND{ib}}});
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_go = 1'b0;
      payload  = ~payload;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [PW-1:0] pl;
    rst_n = 1'b0; frame_go = 1'b0; data_valid = 1'b0; payload = '0; idle_byte = 8'h00;
    repeat (3) @(negedge clk);
    check(!frame_vld && frame_out == '0, "R1 reset state", frame_out, '0);
    rst_n = 1'b1;
    gap(2);
    // first frame: comma must be negative form (R1, R3)
    for (int i = 0; i < ND; i++) pl[8*i +: 8] = 8'(i + 1);
    send(1'b1, pl, 8'h55);
    gap(3);
    // sweep every byte value, two offsets, back-to-back (R4 R6 R7 R9)
    for (int f = 0; f < 48; f++) begin
      for (int i = 0; i < ND; i++) pl[8*i +: 8] = 8'((f * ND + i) + ((f >= 24) ? 128 : 0));
      send(1'b1, pl, 8'hA5);
    end
    gap(2);
    // idle frames, payload must have no effect (R5, R8 with byte 0xBC)
    send(1'b0, {ND{8'hBC}} ^ {PW{1'b1}}, 8'hBC);
    send(1'b0, '1, 8'h00);
    gap(1);
    send(1'b0, '0, 8'hFF);
    send(1'b0, pl, 8'hF1);
    send(1'b1, {ND{8'hFB}}, 8'h07);
    send(1'b1, {ND{8'hEB}}, 8'h07);
    gap(4);
    // mid-stream reset: disparity restarts negative (R1)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!frame_vld && frame_out == '0, "R1 reset mid-stream", frame_out, '0);
    rst_n = 1'b1;
    for (int i = 0; i < ND; i++) pl[8*i +: 8] = 8'(8'hF1 + i);
    send(1'b1, pl, 8'h00);
    send(1'b0, pl, 8'hF4);
    gap(3);
    check(exp_q.size() == 0, "R2 frames missing", FW'(exp_q.size()), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule